// File: doc/BRIEF.md
# Indirect Command Bridge to a 32-bit Peripheral Bus

The bridge sits between a control-side register port that moves 64-bit words and an internal peripheral bus addressed with 32 bits. Software never touches the peripheral bus directly. It loads a payload into a data register, then writes a command word. The bridge issues exactly one bus transaction of 0 to 8 bytes and records the outcome in a status word.

A write command sends the 32-bit payload with its most significant byte first. A read command packs the returned 32 bits into a fixed field of the status word, next to a completion flag. Reading the status word returns it and clears it, so software polls status until the flag shows. While a transaction is outstanding, status reads as zero and further commands are dropped.

Top module: `bridge_top`

## Requirements
- R1: Only `reg_addr[4:3]` selects the register (0 command, 1 reset, 2 status, 3 data); higher and lower address bits are ignored. An access acts only when `reg_be` is all ones; any other access is acknowledged, returns zero and changes nothing.
- R2: A command word (LSB-0 numbering) uses bit 48 as the direction (1 read, 0 write), bits 59:56 as the byte count and bits 31:0 as the bus address; these appear on `bus_we` (inverted direction), `bus_cnt` and `bus_addr`.
- R3: A command with a byte count above 8 starts no bus transaction and leaves status unchanged; a count of exactly 8 is accepted.
- R4: A read that completes without error sets status to bit 11 (done) OR'd with `bus_rdata` shifted left by 26, so the first bus byte (`bus_rdata[31:24]`) sits at status bits 57:50.
- R5: A read that completes with `bus_err` set leaves status as bit 11 with bits 57:26 all ones.
- R6: A write to the data register keeps `reg_wdata[63:32]`; reading it returns that value in bits 63:32 with bits 31:0 zero.
- R7: A write transaction drives the stored data register on `bus_wdata` (first byte in bits 31:24); on completion status is bit 11 alone, whatever `bus_err` says.
- R8: Reading status returns its value and clears it to zero.
- R9: Reads of the command and reset registers return zero; writes to the reset and status registers have no effect.
- R10: `bus_req` stays high with address, direction, count and payload stable until `bus_ready` is seen; completion is recorded only on that cycle.
- R11: A command written while a transaction is outstanding is dropped, and status reads zero until the outstanding transaction completes.
- R12: Every register access is acknowledged on `reg_ack` exactly one cycle later, with `reg_rdata` valid in that cycle (zero for writes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_we | input | 1 | 1 for register write, 0 for read |
| reg_addr | input | REG_AW | Byte address of the register access |
| reg_be | input | 8 | Byte lanes; must be all ones for the access to act |
| reg_wdata | input | 64 | Register write value |
| reg_ack | output | 1 | Access acknowledge, one cycle after `reg_req` |
| reg_rdata | output | 64 | Register read value, valid with `reg_ack` |
| bus_req | output | 1 | Peripheral bus transaction request |
| bus_we | output | 1 | 1 for a bus write, 0 for a bus read |
| bus_addr | output | 32 | Bus address |
| bus_cnt | output | 4 | Byte count, 0 to 8 |
| bus_wdata | output | 32 | Write payload, first byte in bits 31:24 |
| bus_rdata | input | 32 | Read return, first byte in bits 31:24 |
| bus_ready | input | 1 | Bus completion for the current request |
| bus_err | input | 1 | Bus error, sampled with `bus_ready` |

## Verification
Bus reads are answered with a byte pattern whose four bytes differ, so a swapped or misplaced byte in the status field shows at once. The same reads are repeated with the error flag set, and writes are made with an error reply, which separates the all-ones substitution on reads from the unconditional done-only result on writes. Commands with counts 8 and 9 bracket the acceptance limit. A slow responder exposes both the dropped second command and the zero status during the wait, and partial-lane and aliased addresses check that the decode looks at only the lane mask and the two select bits.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int WORD_W    = 64;
  localparam int HALF_W    = 32;
  localparam int BE_W      = WORD_W / 8;
  localparam int BUS_AW    = 32;
  localparam int CNT_W     = 4;
  localparam int MAX_BYTES = 8;
  localparam int SEL_LSB   = 3;

  // command word fields, LSB-0 numbering
  localparam int DIR_BIT   = 48;
  localparam int CNT_LSB   = 56;
  // status word fields
  localparam int DONE_BIT  = 11;
  localparam int RDATA_LSB = 26;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              is_read;
    logic [CNT_W-1:0]  cnt;
    logic [BUS_AW-1:0] addr;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.is_read = w[DIR_BIT];
    c.cnt     = w[CNT_LSB +: CNT_W];
    c.addr    = w[BUS_AW-1:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic [HALF_W-1:0] d);
    logic [WORD_W-1:0] s;
    s = '0;
    s[DONE_BIT] = 1'b1;
    s[RDATA_LSB +: HALF_W] = d;
    return s;
  endfunction
endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
  import bridge_pkg::*;
(
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        sel_bits,
  input  logic [BE_W-1:0]   be,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  output logic              acc_ok,
  output reg_sel_e          sel,
  output logic              start,
  output cmd_t              cmd,
  output logic              data_wr,
  output logic              stat_rd
);
  assign sel    = reg_sel_e'(sel_bits);
  assign acc_ok = req && (be == {BE_W{1'b1}});
  assign cmd    = unpack_cmd(wdata);

  always_comb begin
    start   = 1'b0;
    data_wr = 1'b0;
    stat_rd = 1'b0;
    if (acc_ok) begin
      if (we) begin
        unique case (sel)
          SEL_CMD:  start   = !busy && (cmd.cnt <= CNT_W'(MAX_BYTES));
          SEL_DATA: data_wr = 1'b1;
          default:  ;
        endcase
      end else begin
        stat_rd = (sel == SEL_STAT);
      end
    end
  end
endmodule

// File: rtl/bridge_engine.sv
module bridge_engine
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  cmd_t              cmd,
  input  logic [HALF_W-1:0] payload,
  output logic              busy,
  output logic              done,
  output logic              done_rd,
  output logic              done_err,
  output logic [HALF_W-1:0] done_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [CNT_W-1:0]  bus_cnt,
  output logic [HALF_W-1:0] bus_wdata,
  input  logic [HALF_W-1:0] bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_cnt   <= '0;
      bus_wdata <= '0;
    end else if (bus_req) begin
      if (bus_ready) bus_req <= 1'b0;
    end else if (start) begin
      bus_req   <= 1'b1;
      bus_we    <= !cmd.is_read;
      bus_addr  <= cmd.addr;
      bus_cnt   <= cmd.cnt;
      bus_wdata <= payload;
    end
  end

  assign busy       = bus_req;
  assign done       = bus_req && bus_ready;
  assign done_rd    = !bus_we;
  assign done_err   = bus_err;
  assign done_rdata = bus_rdata;

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_cnt) && $stable(bus_wdata)));

  assert_cnt_limit_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_cnt <= CNT_W'(MAX_BYTES)));
endmodule

// File: rtl/bridge_top.sv
module bridge_top
  import bridge_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BE_W-1:0]   reg_be,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic              reg_ack,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [CNT_W-1:0]  bus_cnt,
  output logic [HALF_W-1:0] bus_wdata,
  input  logic [HALF_W-1:0] bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_err
);
  localparam int SEL_MSB = SEL_LSB + 1;

  logic              acc_ok, start, data_wr, stat_rd;
  reg_sel_e          sel;
  cmd_t              cmd;
  logic              busy, done, done_rd, done_err;
  logic [HALF_W-1:0] done_rdata;
  logic [HALF_W-1:0] data_q;
  logic [WORD_W-1:0] stat_q;
  logic              unused_addr_bits;

  assign unused_addr_bits = ^{reg_addr[REG_AW-1:SEL_MSB+1], reg_addr[SEL_LSB-1:0]};

  bridge_decode u_decode (
    .req      (reg_req),
    .we       (reg_we),
    .sel_bits (reg_addr[SEL_MSB:SEL_LSB]),
    .be       (reg_be),
    .wdata    (reg_wdata),
    .busy     (busy),
    .acc_ok   (acc_ok),
    .sel      (sel),
    .start    (start),
    .cmd      (cmd),
    .data_wr  (data_wr),
    .stat_rd  (stat_rd)
  );

  bridge_engine u_engine (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cmd        (cmd),
    .payload    (data_q),
    .busy       (busy),
    .done       (done),
    .done_rd    (done_rd),
    .done_err   (done_err),
    .done_rdata (done_rdata),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_cnt    (bus_cnt),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .bus_err    (bus_err)
  );

  // register state
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      stat_q <= '0;
    end else begin
      if (data_wr) data_q <= reg_wdata[WORD_W-1:HALF_W];
      if (done) begin
        if (!done_rd)     stat_q <= pack_status('0);
        else if (done_err) stat_q <= pack_status({HALF_W{1'b1}});
        else               stat_q <= pack_status(done_rdata);
      end else if (start || stat_rd) begin
        stat_q <= '0;
      end
    end
  end

  // register read return, one cycle after the request
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ack   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ack   <= reg_req;
      reg_rdata <= '0;
      if (acc_ok && !reg_we) begin
        unique case (sel)
          SEL_STAT: reg_rdata <= stat_q;
          SEL_DATA: reg_rdata <= {data_q, {HALF_W{1'b0}}};
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  assert_ack_next_R12: assert property (@(posedge clk) disable iff (rst)
    reg_req |=> reg_ack);

  assert_stat_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (stat_q == '0));

  assert_stat_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !done) |=> (stat_q == '0));

  assert_write_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_we) |=> (reg_rdata == '0));
endmodule

// File: tb/test_bridge_top.sv
module test_bridge_top;
  localparam int REG_AW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [7:0]  reg_be = '0;
  logic [63:0] reg_wdata = '0;
  logic        reg_ack;
  logic [63:0] reg_rdata;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr;
  logic [3:0]  bus_cnt;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;
  logic        bus_err = 1'b0;

  bridge_top #(.REG_AW(REG_AW)) i_bridge_top (
    .clk(clk), .rst(rst),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_cnt(bus_cnt),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err)
  );

  always #10 clk = ~clk;  // 50 MHz

  int vectors = 0;
  int fails   = 0;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard: expected read return per access
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (!rst && reg_ack) begin
      if (exp_q.size() == 0) begin
        check(64'd1, 64'd0, "R12 unexpected ack");
      end else begin
        check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  // bus responder
  int          resp_delay = 0;
  logic [31:0] resp_data  = '0;
  logic        resp_err   = 1'b0;
  int          wait_cnt   = 0;
  int          txn_cnt    = 0;
  logic [31:0] cap_addr, cap_wdata, first_addr;
  logic        cap_we;
  logic [3:0]  cap_cnt;

  always @(negedge clk) begin
    if (rst) begin
      bus_ready = 1'b0;
      wait_cnt  = 0;
    end else if (bus_req && !bus_ready) begin
      if (wait_cnt == 0) first_addr = bus_addr;
      if (wait_cnt == resp_delay) begin
        check({32'd0, bus_addr}, {32'd0, first_addr}, "R10 address held until ready");
        bus_ready = 1'b1;
        bus_rdata = resp_data;
        bus_err   = resp_err;
        cap_addr  = bus_addr;
        cap_we    = bus_we;
        cap_cnt   = bus_cnt;
        cap_wdata = bus_wdata;
        txn_cnt++;
        wait_cnt  = 0;
      end else begin
        wait_cnt++;
      end
    end else begin
      bus_ready = 1'b0;
    end
  end

  task automatic access(input logic we, input logic [REG_AW-1:0] a, input logic [63:0] d,
                        input logic [7:0] be, input logic [63:0] exp, input string tag);
    reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d; reg_be = be;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0; reg_be = '0;
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input logic [63:0] d);
    access(1'b1, a, d, 8'hFF, 64'd0, "R12 write returns zero");
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, input logic [63:0] exp, input string tag);
    access(1'b0, a, 64'd0, 8'hFF, exp, tag);
  endtask

  function automatic logic [63:0] cmd_word(input logic is_rd, input logic [3:0] cnt,
                                           input logic [31:0] a);
    return ({63'd0, is_rd} << 48) | ({60'd0, cnt} << 56) | {32'd0, a};
  endfunction

  function automatic logic [63:0] stat_word(input logic [31:0] d);
    return (64'd1 << 11) | ({32'd0, d} << 26);
  endfunction

  localparam logic [REG_AW-1:0] A_CMD = 8'h00, A_RST = 8'h08, A_STAT = 8'h10, A_DATA = 8'h18;
  localparam logic [63:0] DONE_ONLY = 64'h0000_0000_0000_0800;

  task automatic settle();
    repeat (resp_delay + 6) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({63'd0, bus_req}, 64'd0, "R10 no request after reset");
    check({63'd0, reg_ack}, 64'd0, "R12 no ack after reset");
    rd(A_STAT, 64'd0, "R8 status zero after reset");
    rd(A_CMD,  64'd0, "R9 command reads zero");
    rd(A_RST,  64'd0, "R9 reset reads zero");
    rd(A_DATA, 64'd0, "R6 data zero after reset");

    // R6 data register keeps upper half
    wr(A_DATA, 64'hA1B2_C3D4_5566_7788);
    rd(A_DATA, 64'hA1B2_C3D4_0000_0000, "R6 data upper half only");

    // R1 partial lanes and aliasing
    access(1'b1, A_DATA, 64'h1111_2222_3333_4444, 8'h0F, 64'd0, "R1 partial write ack");
    rd(A_DATA, 64'hA1B2_C3D4_0000_0000, "R1 partial write ignored");
    rd(8'h38, 64'hA1B2_C3D4_0000_0000, "R1 alias on select bits only");
    access(1'b0, A_DATA, 64'd0, 8'hF0, 64'd0, "R1 partial read returns zero");
    base = txn_cnt;
    access(1'b1, A_CMD, cmd_word(1'b0, 4'd4, 32'h10), 8'h7F, 64'd0, "R1 partial command ack");
    settle();
    check(64'(txn_cnt), 64'(base), "R1 partial command starts nothing");

    // R7 bus write with error reply, R2 fields
    resp_delay = 2; resp_err = 1'b1;
    wr(A_CMD, cmd_word(1'b0, 4'd4, 32'h0000_1234));
    settle();
    check(64'(txn_cnt), 64'(base + 1), "R7 one write transaction");
    check({32'd0, cap_addr}, 64'h1234, "R2 bus address");
    check({63'd0, cap_we}, 64'd1, "R2 write direction");
    check({60'd0, cap_cnt}, 64'd4, "R2 byte count");
    check({32'd0, cap_wdata}, 64'hA1B2C3D4, "R7 payload first byte high");
    rd(A_STAT, DONE_ONLY, "R7 write status done only despite error");

    // R4 successful read, R8 read-clear
    resp_delay = 0; resp_err = 1'b0; resp_data = 32'h1122_3344;
    wr(A_CMD, cmd_word(1'b1, 4'd4, 32'hD001_0060));
    settle();
    check({63'd0, cap_we}, 64'd0, "R2 read direction");
    check({32'd0, cap_addr}, 64'hD001_0060, "R2 read address");
    rd(A_STAT, stat_word(32'h1122_3344), "R4 read data packed");
    rd(A_STAT, 64'd0, "R8 status cleared by read");

    // R5 failed read
    resp_err = 1'b1; resp_data = 32'h0;
    wr(A_CMD, cmd_word(1'b1, 4'd2, 32'h40));
    settle();
    rd(A_STAT, stat_word(32'hFFFF_FFFF), "R5 error read forces ones");

    // R3 count 8 accepted, count 9 rejected with status kept
    resp_err = 1'b0; resp_data = 32'hCAFE_F00D;
    wr(A_CMD, cmd_word(1'b1, 4'd8, 32'h80));
    settle();
    check({60'd0, cap_cnt}, 64'd8, "R3 count of eight accepted");
    base = txn_cnt;
    wr(A_CMD, cmd_word(1'b1, 4'd9, 32'h90));
    settle();
    check(64'(txn_cnt), 64'(base), "R3 count nine starts nothing");

    // R9 writes to reset and status do nothing
    wr(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(A_STAT, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_STAT, stat_word(32'hCAFE_F00D), "R3 R9 status unchanged");

    // R11 busy: status zero and second command dropped
    resp_delay = 6; resp_data = 32'h0A0B_0C0D;
    base = txn_cnt;
    wr(A_CMD, cmd_word(1'b1, 4'd1, 32'h0000_0100));
    rd(A_STAT, 64'd0, "R11 status zero while busy");
    wr(A_CMD, cmd_word(1'b0, 4'd1, 32'h0000_0200));
    settle();
    check(64'(txn_cnt), 64'(base + 1), "R11 second command dropped");
    check({32'd0, cap_addr}, 64'h100, "R11 first command kept");
    rd(A_STAT, stat_word(32'h0A0B_0C0D), "R10 R11 status after slow ready");

    repeat (4) @(negedge clk);
    check(64'(exp_q.size()), 64'd0, "R12 every access acknowledged");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule